// File: doc/BRIEF.md
# Program and Data Address Map Decoder

This block sits beside a 14-bit signal-processor core and turns each program-space and data-space address into a single target choice. The program-space targets are internal RAM, a fixed on-chip ROM window, the external bus, or a reserved slot. The data-space targets are internal RAM, a control register, the external bus, or a reserved slot. A layout strap is captured while reset is held. It places internal program RAM either at the bottom or at the top of program space, and it also decides whether a boot-load request is raised once reset is released.

A one-bit ROM-enable flag lives in a control word in data space. Setting the flag makes the program window 0x0800–0x17FF select the on-chip ROM in either layout. The last sixteen words of that window select the reserved target. Clearing the flag sends the whole window back to whatever the layout places there, which is always external memory.

All select outputs are registered, so a select appears one clock after the request. The memories and the boot sequencer are separate blocks that act on these selects.

Top module: `mmd_top`

## Requirements
- R1: With the latched strap at 0 and ROM-enable at 0, program addresses 0x0000–0x07FF select internal RAM and 0x0800–0x3FFF select external memory.
- R2: With the latched strap at 1 and ROM-enable at 0, program addresses 0x3800–0x3FFF select internal RAM and 0x0000–0x37FF select external memory.
- R3: The strap is sampled on every clock edge while `rst` is high and then held. Changing `strap_i` after reset has no effect on the program map.
- R4: `boot_req_o` is high for exactly one cycle. It rises after the first clock edge at which `rst` is low, and only if the latched strap is 0. It never rises when the strap is 1.
- R5: With ROM-enable at 1, program addresses 0x0800–0x17EF select the ROM under either strap value.
- R6: With ROM-enable at 1, program addresses 0x17F0–0x17FF select the reserved target. With ROM-enable at 0, that whole window maps as R1 or R2 say.
- R7: The control word is at data address 0x3FFE, and its bit 0 is ROM-enable. A data write there loads bit 0, and `rom_en_o` shows the new value one cycle later. A read returns ROM-enable in bit 0 and zeros in the other bits. Reset clears ROM-enable to 0.
- R8: Data addresses 0x3000–0x37FF select internal RAM. Address 0x3FFE selects the control register. The other addresses in 0x3800–0x3FFF select reserved. All remaining data addresses select external memory.
- R9: Data reads of any address other than 0x3FFE return zero on `dm_rdata_o`. Writes to reserved data addresses leave ROM-enable unchanged.
- R10: Select encoding is bit 0 internal RAM, bit 1 ROM, bit 2 control register, bit 3 external, bit 4 reserved. One cycle after a request exactly one bit is set. One cycle after no request, and during reset, all bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_i | input | 1 | Layout strap, captured while reset is high |
| pm_req_i | input | 1 | Program-space access request |
| pm_addr_i | input | 14 | Program-space address |
| dm_req_i | input | 1 | Data-space access request |
| dm_we_i | input | 1 | Data-space write when high, read when low |
| dm_addr_i | input | 14 | Data-space address |
| dm_wdata_i | input | 16 | Data-space write data |
| pm_sel_o | output | 5 | Registered one-hot program target select |
| dm_sel_o | output | 5 | Registered one-hot data target select |
| dm_rdata_o | output | 16 | Registered control-word read data |
| rom_en_o | output | 1 | Current ROM-enable flag |
| boot_req_o | output | 1 | One-cycle boot-load request after reset |

## Verification
A wrong latched strap shows up at once. The first program access to 0x0000 or 0x3800 selects the wrong target, and the boot pulse either appears or goes missing on the cycle right after reset is released. A stuck or wrongly written ROM-enable flag shows up on the first access inside the window 0x0800–0x17FF, on `rom_en_o`, and on a read of the control word one cycle after the request. The bench sweeps every program address under all four combinations of strap and flag, and every data address, so any decode boundary that is off by one word is caught on the access to that word.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  localparam int NTGT = 5;

  typedef enum logic [2:0] {
    TGT_IRAM = 3'd0,
    TGT_ROM  = 3'd1,
    TGT_CTRL = 3'd2,
    TGT_EXT  = 3'd3,
    TGT_RSVD = 3'd4
  } tgt_e;

  typedef logic [NTGT-1:0] sel_t;

  function automatic sel_t tgt_onehot(tgt_e t);
    sel_t v;
    v = '0;
    v[t] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/mmd_strap_ctl.sv
module mmd_strap_ctl (
  input  logic clk,
  input  logic rst,
  input  logic strap_i,
  output logic strap_q,
  output logic boot_req
);

  logic in_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_rst   <= 1'b1;
      strap_q  <= strap_i;
      boot_req <= 1'b0;
    end else begin
      in_rst   <= 1'b0;
      boot_req <= in_rst & ~strap_q;
    end
  end

endmodule

// File: rtl/mmd_pm_decode.sv
module mmd_pm_decode
  import mmd_pkg::*;
#(
  parameter int AW        = 14,
  parameter int RAM_WORDS = 2048,
  parameter int ROM_BASE  = 2048,
  parameter int ROM_WORDS = 4096,
  parameter int ROM_RSVD  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [AW-1:0] addr,
  input  logic          strap_q,
  input  logic          rom_en,
  output sel_t          sel
);

  localparam logic [AW-1:0] LO_RAM_END  = AW'(RAM_WORDS);
  localparam logic [AW-1:0] HI_RAM_BASE = AW'((2**AW) - RAM_WORDS);

  tgt_e layout_tgt;
  tgt_e final_tgt;
  logic in_window;
  logic in_tail;

  always_comb begin
    if (!strap_q) layout_tgt = (addr < LO_RAM_END) ? TGT_IRAM : TGT_EXT;
    else          layout_tgt = (addr >= HI_RAM_BASE) ? TGT_IRAM : TGT_EXT;
  end

  generate
    if (ROM_WORDS > 0) begin : g_rom
      localparam logic [AW-1:0] W_LO   = AW'(ROM_BASE);
      localparam logic [AW-1:0] W_HI   = AW'(ROM_BASE + ROM_WORDS - 1);
      localparam logic [AW-1:0] W_TAIL = AW'(ROM_BASE + ROM_WORDS - ROM_RSVD);
      always_comb begin
        in_window = rom_en && (addr >= W_LO) && (addr <= W_HI);
        in_tail   = addr >= W_TAIL;
      end
    end else begin : g_norom
      always_comb begin
        in_window = 1'b0;
        in_tail   = rom_en & 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (in_window) final_tgt = in_tail ? TGT_RSVD : TGT_ROM;
    else           final_tgt = layout_tgt;
  end

  always_ff @(posedge clk) begin
    if (rst)      sel <= '0;
    else if (req) sel <= tgt_onehot(final_tgt);
    else          sel <= '0;
  end

endmodule

// File: rtl/mmd_dm_port.sv
module mmd_dm_port
  import mmd_pkg::*;
#(
  parameter int AW         = 14,
  parameter int DW         = 16,
  parameter int DRAM_BASE  = 12288,
  parameter int DRAM_WORDS = 2048,
  parameter int CTRL_BASE  = 14336,
  parameter int CTRL_ADDR  = 16382,
  parameter int ROMEN_BIT  = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output sel_t          sel,
  output logic [DW-1:0] rdata,
  output logic          rom_en
);

  localparam logic [AW-1:0] RAM_LO  = AW'(DRAM_BASE);
  localparam logic [AW-1:0] RAM_HI  = AW'(DRAM_BASE + DRAM_WORDS - 1);
  localparam logic [AW-1:0] RSV_LO  = AW'(CTRL_BASE);
  localparam logic [AW-1:0] CTRL_A  = AW'(CTRL_ADDR);

  tgt_e tgt;
  logic hit_ctrl;

  always_comb begin
    hit_ctrl = (addr == CTRL_A);
    if (hit_ctrl)                            tgt = TGT_CTRL;
    else if (addr >= RSV_LO)                 tgt = TGT_RSVD;
    else if (addr >= RAM_LO && addr <= RAM_HI) tgt = TGT_IRAM;
    else                                     tgt = TGT_EXT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel    <= '0;
      rdata  <= '0;
      rom_en <= 1'b0;
    end else begin
      sel   <= req ? tgt_onehot(tgt) : '0;
      rdata <= (req && !we && hit_ctrl) ? (DW'(rom_en) << ROMEN_BIT) : '0;
      if (req && we && hit_ctrl) rom_en <= wdata[ROMEN_BIT];
    end
  end

endmodule

// File: rtl/mmd_top.sv
module mmd_top
  import mmd_pkg::*;
#(
  parameter int AW         = 14,
  parameter int DW         = 16,
  parameter int PRAM_WORDS = 2048,
  parameter int ROM_BASE   = 2048,
  parameter int ROM_WORDS  = 4096,
  parameter int ROM_RSVD   = 16,
  parameter int DRAM_BASE  = 12288,
  parameter int DRAM_WORDS = 2048,
  parameter int CTRL_BASE  = 14336,
  parameter int CTRL_ADDR  = 16382,
  parameter int ROMEN_BIT  = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            strap_i,
  input  logic            pm_req_i,
  input  logic [AW-1:0]   pm_addr_i,
  input  logic            dm_req_i,
  input  logic            dm_we_i,
  input  logic [AW-1:0]   dm_addr_i,
  input  logic [DW-1:0]   dm_wdata_i,
  output logic [NTGT-1:0] pm_sel_o,
  output logic [NTGT-1:0] dm_sel_o,
  output logic [DW-1:0]   dm_rdata_o,
  output logic            rom_en_o,
  output logic            boot_req_o
);

  logic strap_q;
  logic rom_en;

  mmd_strap_ctl u_strap (
    .clk      (clk),
    .rst      (rst),
    .strap_i  (strap_i),
    .strap_q  (strap_q),
    .boot_req (boot_req_o)
  );

  mmd_pm_decode #(
    .AW(AW), .RAM_WORDS(PRAM_WORDS), .ROM_BASE(ROM_BASE),
    .ROM_WORDS(ROM_WORDS), .ROM_RSVD(ROM_RSVD)
  ) u_pm (
    .clk     (clk),
    .rst     (rst),
    .req     (pm_req_i),
    .addr    (pm_addr_i),
    .strap_q (strap_q),
    .rom_en  (rom_en),
    .sel     (pm_sel_o)
  );

  mmd_dm_port #(
    .AW(AW), .DW(DW), .DRAM_BASE(DRAM_BASE), .DRAM_WORDS(DRAM_WORDS),
    .CTRL_BASE(CTRL_BASE), .CTRL_ADDR(CTRL_ADDR), .ROMEN_BIT(ROMEN_BIT)
  ) u_dm (
    .clk    (clk),
    .rst    (rst),
    .req    (dm_req_i),
    .we     (dm_we_i),
    .addr   (dm_addr_i),
    .wdata  (dm_wdata_i),
    .sel    (dm_sel_o),
    .rdata  (dm_rdata_o),
    .rom_en (rom_en)
  );

  assign rom_en_o = rom_en;

endmodule

// File: rtl/mmd_checker.sv
module mmd_checker #(
  parameter int AW        = 14,
  parameter int DW        = 16,
  parameter int CTRL_ADDR = 16382
) (
  input logic          clk,
  input logic          rst,
  input logic          pm_req_i,
  input logic          dm_req_i,
  input logic          dm_we_i,
  input logic [AW-1:0] dm_addr_i,
  input logic [4:0]    pm_sel_o,
  input logic [4:0]    dm_sel_o,
  input logic [DW-1:0] dm_rdata_o,
  input logic          rom_en_o,
  input logic          boot_req_o
);

  logic pm_req_q, dm_req_q, zero_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_req_q  <= 1'b0;
      dm_req_q  <= 1'b0;
      zero_rd_q <= 1'b0;
    end else begin
      pm_req_q  <= pm_req_i;
      dm_req_q  <= dm_req_i;
      zero_rd_q <= dm_req_i && !dm_we_i && (dm_addr_i != AW'(CTRL_ADDR));
    end
  end

  p_pm_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    pm_req_q |-> $onehot(pm_sel_o));
  p_pm_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !pm_req_q |-> (pm_sel_o == '0));
  p_dm_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    dm_req_q |-> $onehot(dm_sel_o));
  p_dm_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !dm_req_q |-> (dm_sel_o == '0));
  p_rom_gated_r5: assert property (@(posedge clk) disable iff (rst)
    pm_sel_o[1] |-> $past(rom_en_o));
  p_boot_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    boot_req_o |=> !boot_req_o);
  p_romen_reset_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !rom_en_o);
  p_zero_read_r9: assert property (@(posedge clk) disable iff (rst)
    zero_rd_q |-> (dm_rdata_o == '0));
  p_rsvd_write_r9: assert property (@(posedge clk) disable iff (rst)
    (dm_req_i && dm_we_i && dm_addr_i != AW'(CTRL_ADDR)) |=> $stable(rom_en_o));

endmodule

bind mmd_top mmd_checker #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) u_chk (.*);

// File: tb/tb_mmd_top.sv
module tb_mmd_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_i = 1'b0;
  logic        pm_req_i = 1'b0;
  logic [13:0] pm_addr_i = '0;
  logic        dm_req_i = 1'b0;
  logic        dm_we_i = 1'b0;
  logic [13:0] dm_addr_i = '0;
  logic [15:0] dm_wdata_i = '0;
  logic [4:0]  pm_sel_o, dm_sel_o;
  logic [15:0] dm_rdata_o;
  logic        rom_en_o, boot_req_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mmd_top dut (
    .clk(clk), .rst(rst), .strap_i(strap_i),
    .pm_req_i(pm_req_i), .pm_addr_i(pm_addr_i),
    .dm_req_i(dm_req_i), .dm_we_i(dm_we_i), .dm_addr_i(dm_addr_i),
    .dm_wdata_i(dm_wdata_i), .pm_sel_o(pm_sel_o), .dm_sel_o(dm_sel_o),
    .dm_rdata_o(dm_rdata_o), .rom_en_o(rom_en_o), .boot_req_o(boot_req_o)
  );

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_pm(int a, bit s, bit re);
    if (re && a >= 'h0800 && a <= 'h17FF) return (a >= 'h17F0) ? 16 : 2;
    if (!s) return (a < 'h0800) ? 1 : 8;
    return (a >= 'h3800) ? 1 : 8;
  endfunction

  function automatic string tag_pm(int a, bit s, bit re);
    if (a >= 'h0800 && a <= 'h17FF) begin
      if (!re || a >= 'h17F0) return "R6";
      return "R5";
    end
    return s ? "R2" : "R1";
  endfunction

  function automatic int exp_dm(int a);
    if (a == 'h3FFE) return 4;
    if (a >= 'h3800) return 16;
    if (a >= 'h3000) return 1;
    return 8;
  endfunction

  task automatic do_reset(bit s);
    rst = 1'b1;
    strap_i = s;
    repeat (3) @(negedge clk);
    chk("R10 reset pm_sel", int'(pm_sel_o), 0);
    chk("R10 reset dm_sel", int'(dm_sel_o), 0);
    chk("R7 reset rom_en", int'(rom_en_o), 0);
    chk("R4 no boot in reset", int'(boot_req_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 boot pulse", int'(boot_req_o), s ? 0 : 1);
    strap_i = ~s;
    @(negedge clk);
    chk("R4 boot ends", int'(boot_req_o), 0);
  endtask

  task automatic pm_sweep(bit s, bit re);
    for (int a = 0; a < 16384; a++) begin
      pm_req_i = 1'b1;
      pm_addr_i = 14'(a);
      @(negedge clk);
      chk(tag_pm(a, s, re), int'(pm_sel_o), exp_pm(a, s, re));
    end
    pm_req_i = 1'b0;
    @(negedge clk);
    chk("R10 pm idle", int'(pm_sel_o), 0);
  endtask

  task automatic dm_op(bit w, int a, int d);
    dm_req_i = 1'b1;
    dm_we_i = w;
    dm_addr_i = 14'(a);
    dm_wdata_i = 16'(d);
    @(negedge clk);
    dm_req_i = 1'b0;
    dm_we_i = 1'b0;
  endtask

  task automatic dm_sweep(bit re);
    for (int a = 0; a < 16384; a++) begin
      dm_req_i = 1'b1;
      dm_we_i = 1'b0;
      dm_addr_i = 14'(a);
      @(negedge clk);
      chk("R8 dm map", int'(dm_sel_o), exp_dm(a));
      if (a == 'h3FFE) chk("R7 ctrl read", int'(dm_rdata_o), int'(re));
      else             chk("R9 zero read", int'(dm_rdata_o), 0);
    end
    dm_req_i = 1'b0;
    @(negedge clk);
    chk("R10 dm idle", int'(dm_sel_o), 0);
  endtask

  task automatic leg(bit s);
    do_reset(s);
    // R3: strap_i now differs from the latched value
    pm_sweep(s, 1'b0);
    dm_op(1'b1, 'h3FFE, 'hFFFF);
    chk("R7 write sets rom_en", int'(rom_en_o), 1);
    dm_op(1'b0, 'h3FFE, 0);
    chk("R7 readback", int'(dm_rdata_o), 1);
    pm_sweep(s, 1'b1);
    dm_sweep(1'b1);
    for (int a = 'h3800; a < 16384; a++) begin
      if (a != 'h3FFE) begin
        dm_op(1'b1, a, 0);
        chk("R9 rsvd write ignored", int'(rom_en_o), 1);
      end
    end
    dm_op(1'b0, 'h3FFE, 0);
    chk("R9 ctrl intact", int'(dm_rdata_o), 1);
    dm_op(1'b1, 'h3FFE, 'hFFFE);
    chk("R7 write clears rom_en", int'(rom_en_o), 0);
    dm_op(1'b1, 'h3FFE, 1);
    chk("R7 write sets again", int'(rom_en_o), 1);
  endtask

  initial begin
    leg(1'b0);
    leg(1'b1);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule